// File: doc/BRIEF.md
# PCI Type-0 Configuration Write Target

This block is the target side of a 32-bit PCI bus for one kind of cycle only: the Type-0 configuration write. It samples the bus framing, select, command/byte-enable and address/data lines on every rising clock edge. It recognises an address phase addressed to this device and splits that address into a dword register index and a function number. It then claims the cycle with slow decode timing and takes exactly one data dword. To close the cycle it signals a disconnect with data, drives the control lines high for one cycle and releases them.

Each accepted dword leaves the block as one item on a valid/ready stream: register index, function number, data and active-high byte enables. The sink may hold `wr_ready` low for as long as it likes. An item that has been presented stays unchanged until the sink accepts it. While that item is still waiting, the next configuration write is claimed but held in wait states, with the target-ready line high, until the holding slot frees. No write is ever dropped or overwritten. The three sustained tri-state control lines share one output enable, which the bus pads use.

Top module: `pci_cfgwr_target`

## Requirements
- R1: After reset, `devseln`, `trdyn` and `stopn` are high, `ctl_oe` is low and `wr_valid` is low.
- R2: A cycle is treated as an address phase only when `framen` is low after having been high in the previous sample. The cycle is claimed only if, in that phase, `idsel` is high, `cben` equals 4'b1011 and `ad[1:0]` equals 2'b00. In every other case `devseln` stays high and `ctl_oe` stays low.
- R3: For a claimed cycle, `devseln` goes low in the third cycle after the address phase, which leaves two decode cycles, and `ctl_oe` is high from that cycle on.
- R4: `trdyn` and `stopn` go low together, one cycle after `devseln` goes low, when the stream slot is free. They stay low until `irdyn` is sampled low.
- R5: In the cycle where `trdyn` and `irdyn` are both low, the dword is captured. In the next cycle `wr_valid` is high with `wr_idx` = `ad[7:2]` and `wr_fn` = `ad[10:8]` from the address phase, `wr_data` = `ad` from the data phase and `wr_be` = ~`cben` from the data phase. `ad[31:11]` has no effect.
- R6: In the cycle after the `trdyn`/`irdyn` handshake, `devseln`, `trdyn` and `stopn` are all driven high with `ctl_oe` still high.
- R7: Two cycles after the handshake `ctl_oe` is low (turnaround), and the target is ready for a new address phase.
- R8: If `framen` and `irdyn` are both sampled high during either decode cycle, the target returns to idle without driving `devseln` low.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_valid` stays high and all item fields stay unchanged. An item is consumed in exactly the cycle where both are high.
- R10: While an earlier item is waiting (`wr_valid` high, `wr_ready` low), a newly claimed cycle keeps `trdyn` and `stopn` high with `devseln` low. `trdyn` goes low only after the slot frees.
- R11: `ctl_oe` is high in every cycle in which any of `devseln`, `trdyn` or `stopn` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| framen | input | 1 | Cycle framing from the master, active low |
| idsel | input | 1 | Configuration select for this device, active high |
| irdyn | input | 1 | Initiator ready, active low |
| cben | input | 4 | Command in the address phase, byte enables (active low) in the data phase |
| ad | input | 32 | Multiplexed address/data |
| devseln | output | 1 | Device select, active low |
| trdyn | output | 1 | Target ready, active low |
| stopn | output | 1 | Stop request, active low |
| ctl_oe | output | 1 | Output enable for devseln, trdyn and stopn |
| wr_valid | output | 1 | Write item valid |
| wr_ready | input | 1 | Sink accepts the item |
| wr_idx | output | 6 | Dword register index |
| wr_fn | output | 3 | Function number |
| wr_data | output | 32 | Write data |
| wr_be | output | 4 | Byte enables, active high |

## Verification
The bench builds the block with its default parameters: two decode cycles and the configuration write command code 4'b1011. With these values the exact cycle of the claim and of target-ready can be predicted and checked at fixed offsets. The short decode window also lets an aborted decode be tested within one idle gap. Because the holding slot has a single entry, one stalled item is enough to push the next transaction into target wait states. This makes the back-pressure path reachable with two back-to-back writes.

// File: rtl/pci_cfgwr_pkg.sv
package pci_cfgwr_pkg;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int IDX_W  = 6;
  localparam int FN_W   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_CLAIM,
    ST_DATA,
    ST_TURN
  } tgt_state_t;

  typedef struct packed {
    logic [IDX_W-1:0]  idx;
    logic [FN_W-1:0]   fn;
    logic [DATA_W-1:0] data;
    logic [BE_W-1:0]   be;
  } wr_item_t;
endpackage

// File: rtl/pci_cfgwr_addr_dec.sv
module pci_cfgwr_addr_dec
  import pci_cfgwr_pkg::*;
#(
  parameter logic [3:0] CMD_CODE = 4'b1011,
  parameter bit         CHK_TYPE = 1'b1
) (
  input  logic              framen,
  input  logic              framen_q,
  input  logic              idsel,
  input  logic [3:0]        cben,
  input  logic [DATA_W-1:0] ad,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [FN_W-1:0]   fn
);
  localparam int IDX_LSB = 2;
  localparam int FN_LSB  = IDX_LSB + IDX_W;

  logic start;
  logic type_ok;

  assign start = !framen && framen_q;
  assign idx   = ad[IDX_LSB +: IDX_W];
  assign fn    = ad[FN_LSB +: FN_W];

  generate
    if (CHK_TYPE) begin : g_type_chk
      assign type_ok = (ad[1:0] == 2'b00);
    end else begin : g_type_any
      assign type_ok = 1'b1;
    end
  endgenerate

  assign hit = start && idsel && (cben == CMD_CODE) && type_ok;
endmodule

// File: rtl/pci_cfgwr_fsm.sv
module pci_cfgwr_fsm
  import pci_cfgwr_pkg::*;
#(
  parameter int DEC_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             framen,
  input  logic             irdyn,
  input  logic             hit,
  input  logic [IDX_W-1:0] idx_in,
  input  logic [FN_W-1:0]  fn_in,
  input  logic             slot_free,
  output logic             dev_n,
  output logic             trdy_n,
  output logic             stop_n,
  output logic             oe,
  output logic             load,
  output logic [IDX_W-1:0] idx_q,
  output logic [FN_W-1:0]  fn_q
);
  localparam int CNT_W = (DEC_CYCLES > 1) ? $clog2(DEC_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEC_CYCLES - 1);

  tgt_state_t       state, state_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             dev_nx, trdy_nx, stop_nx, oe_nx;
  logic             no_master;

  assign no_master = framen && irdyn;

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    dev_nx   = dev_n;
    trdy_nx  = trdy_n;
    stop_nx  = stop_n;
    oe_nx    = oe;
    load     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (hit) begin
          state_nx = ST_DECODE;
          cnt_nx   = '0;
        end
      end
      ST_DECODE: begin
        if (no_master) begin
          state_nx = ST_IDLE;
        end else if (cnt == CNT_LAST) begin
          state_nx = ST_CLAIM;
          dev_nx   = 1'b0;
          oe_nx    = 1'b1;
        end else begin
          cnt_nx = cnt + 1'b1;
        end
      end
      ST_CLAIM: begin
        if (slot_free) begin
          state_nx = ST_DATA;
          trdy_nx  = 1'b0;
          stop_nx  = 1'b0;
        end
      end
      ST_DATA: begin
        if (!irdyn) begin
          load     = 1'b1;
          state_nx = ST_TURN;
          dev_nx   = 1'b1;
          trdy_nx  = 1'b1;
          stop_nx  = 1'b1;
        end
      end
      ST_TURN: begin
        oe_nx    = 1'b0;
        state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      dev_n  <= 1'b1;
      trdy_n <= 1'b1;
      stop_n <= 1'b1;
      oe     <= 1'b0;
      idx_q  <= '0;
      fn_q   <= '0;
    end else begin
      state  <= state_nx;
      cnt    <= cnt_nx;
      dev_n  <= dev_nx;
      trdy_n <= trdy_nx;
      stop_n <= stop_nx;
      oe     <= oe_nx;
      if (state == ST_IDLE && hit) begin
        idx_q <= idx_in;
        fn_q  <= fn_in;
      end
    end
  end
endmodule

// File: rtl/pci_cfgwr_out_slot.sv
module pci_cfgwr_out_slot
  import pci_cfgwr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  wr_item_t item_in,
  input  logic     ready,
  output logic     valid,
  output wr_item_t item_q,
  output logic     free
);
  assign free = !valid || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      item_q <= '0;
    end else if (load) begin
      valid  <= 1'b1;
      item_q <= item_in;
    end else if (ready) begin
      valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/pci_cfgwr_target.sv
module pci_cfgwr_target
  import pci_cfgwr_pkg::*;
#(
  parameter int         DEC_CYCLES = 2,
  parameter logic [3:0] CMD_CODE   = 4'b1011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              framen,
  input  logic              idsel,
  input  logic              irdyn,
  input  logic [3:0]        cben,
  input  logic [DATA_W-1:0] ad,
  output logic              devseln,
  output logic              trdyn,
  output logic              stopn,
  output logic              ctl_oe,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [FN_W-1:0]   wr_fn,
  output logic [DATA_W-1:0] wr_data,
  output logic [BE_W-1:0]   wr_be
);
  logic             framen_q;
  logic             hit;
  logic [IDX_W-1:0] dec_idx, idx_q;
  logic [FN_W-1:0]  dec_fn, fn_q;
  logic             slot_free, load;
  wr_item_t         item_in, item_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) framen_q <= 1'b1;
    else        framen_q <= framen;
  end

  pci_cfgwr_addr_dec #(.CMD_CODE(CMD_CODE), .CHK_TYPE(1'b1)) u_dec (
    .framen   (framen),
    .framen_q (framen_q),
    .idsel    (idsel),
    .cben     (cben),
    .ad       (ad),
    .hit      (hit),
    .idx      (dec_idx),
    .fn       (dec_fn)
  );

  pci_cfgwr_fsm #(.DEC_CYCLES(DEC_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .framen    (framen),
    .irdyn     (irdyn),
    .hit       (hit),
    .idx_in    (dec_idx),
    .fn_in     (dec_fn),
    .slot_free (slot_free),
    .dev_n     (devseln),
    .trdy_n    (trdyn),
    .stop_n    (stopn),
    .oe        (ctl_oe),
    .load      (load),
    .idx_q     (idx_q),
    .fn_q      (fn_q)
  );

  assign item_in.idx  = idx_q;
  assign item_in.fn   = fn_q;
  assign item_in.data = ad;
  assign item_in.be   = ~cben;

  pci_cfgwr_out_slot u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .item_in (item_in),
    .ready   (wr_ready),
    .valid   (wr_valid),
    .item_q  (item_q),
    .free    (slot_free)
  );

  assign wr_idx  = item_q.idx;
  assign wr_fn   = item_q.fn;
  assign wr_data = item_q.data;
  assign wr_be   = item_q.be;
endmodule

// File: rtl/pci_cfgwr_target_chk.sv
module pci_cfgwr_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        idsel,
  input logic        irdyn,
  input logic        devseln,
  input logic        trdyn,
  input logic        stopn,
  input logic        ctl_oe,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [5:0]  wr_idx,
  input logic [31:0] wr_data
);
  // R3: claim comes three samples after a selected address phase
  a_r3_claim_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devseln) |-> $past(idsel, 3));

  a_r4_trdy_after_devsel: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trdyn) |-> (!devseln && $past(!devseln)));

  a_r4_stop_with_trdy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stopn) |-> $fell(trdyn));

  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdyn && !irdyn) |=> wr_valid);

  a_r6_drive_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdyn && !irdyn) |=> (devseln && trdyn && stopn && ctl_oe));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdyn && !irdyn) |=> ##1 !ctl_oe);

  a_r9_hold_item: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_idx)));

  a_r10_wait_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |-> trdyn);

  a_r11_oe_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (!devseln || !trdyn || !stopn) |-> ctl_oe);
endmodule

bind pci_cfgwr_target pci_cfgwr_target_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .idsel    (idsel),
  .irdyn    (irdyn),
  .devseln  (devseln),
  .trdyn    (trdyn),
  .stopn    (stopn),
  .ctl_oe   (ctl_oe),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_idx   (wr_idx),
  .wr_data  (wr_data)
);

// File: tb/pci_cfgwr_target_test.sv
module pci_cfgwr_target_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        framen = 1'b1, idsel = 1'b0, irdyn = 1'b1, wr_ready = 1'b1;
  logic [3:0]  cben = 4'hF;
  logic [31:0] ad = '0;
  logic        devseln, trdyn, stopn, ctl_oe, wr_valid;
  logic [5:0]  wr_idx;
  logic [2:0]  wr_fn;
  logic [31:0] wr_data;
  logic [3:0]  wr_be;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [44:0] exp_q[$];

  always #(PERIOD/2) clk = ~clk;

  pci_cfgwr_target uut (
    .clk(clk), .rst_n(rst_n), .framen(framen), .idsel(idsel), .irdyn(irdyn),
    .cben(cben), .ad(ad), .devseln(devseln), .trdyn(trdyn), .stopn(stopn),
    .ctl_oe(ctl_oe), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx),
    .wr_fn(wr_fn), .wr_data(wr_data), .wr_be(wr_be)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_idle();
    framen = 1'b1; irdyn = 1'b1; idsel = 1'b0; cben = 4'hF; ad = '0;
  endtask

  // Monitor: pops the scoreboard on each accepted item (R5, R9)
  initial begin
    forever begin
      @(negedge clk); #1;
      if (wr_valid && wr_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected item", {19'd0, wr_idx, wr_fn, wr_data, wr_be}, 64'd0);
        end else begin
          logic [44:0] e;
          e = exp_q.pop_front();
          check({wr_idx, wr_fn, wr_data, wr_be} == e, "R5 item fields",
                {19'd0, wr_idx, wr_fn, wr_data, wr_be}, {19'd0, e});
        end
      end
    end
  end

  // Driver: one configuration write; pushes the expected item
  task automatic cfg_write(input logic [5:0] idx, input logic [2:0] fn,
                           input logic [31:0] data, input logic [3:0] be_n,
                           input int waits, input bit stall, input logic [20:0] upper);
    int wcnt;
    exp_q.push_back({idx, fn, data, ~be_n});
    @(negedge clk);
    framen = 1'b0; idsel = 1'b1; cben = 4'b1011; ad = {upper, fn, idx, 2'b00};
    @(negedge clk);
    idsel = 1'b0; ad = data; cben = be_n; wcnt = waits;
    if (waits == 0) begin framen = 1'b1; irdyn = 1'b0; end
    else begin framen = 1'b0; irdyn = 1'b1; end
    @(negedge clk);
    check(devseln === 1'b1, "R3 devseln still high in decode", devseln, 1);
    @(negedge clk);
    check(devseln === 1'b0, "R3 devseln low third cycle", devseln, 0);
    check(ctl_oe === 1'b1, "R3 oe on with claim", ctl_oe, 1);
    check(trdyn === 1'b1, "R4 trdyn not before devsel", trdyn, 1);
    @(negedge clk);
    if (!stall) begin
      check(trdyn === 1'b0 && stopn === 1'b0, "R4 trdyn and stopn low together",
            {trdyn, stopn}, 2'b00);
    end else begin
      check(trdyn === 1'b1 && devseln === 1'b0, "R10 wait state while slot full",
            {trdyn, devseln}, 2'b10);
      @(negedge clk);
      check(trdyn === 1'b1 && stopn === 1'b1, "R10 still waiting", {trdyn, stopn}, 2'b11);
      wr_ready = 1'b1;
    end
    while (!(trdyn === 1'b0 && irdyn === 1'b0)) begin
      @(negedge clk);
      if (irdyn && !trdyn)
        check(stopn === 1'b0, "R4 held while master waits", stopn, 0);
      if (wcnt > 0) begin
        wcnt--;
        if (wcnt == 0) begin framen = 1'b1; irdyn = 1'b0; end
      end
    end
    @(negedge clk);
    bus_idle();
    check(devseln && trdyn && stopn && ctl_oe, "R6 lines high, oe on",
          {devseln, trdyn, stopn, ctl_oe}, 4'b1111);
    check(wr_valid === 1'b1, "R5 wr_valid after handshake", wr_valid, 1);
    @(negedge clk);
    check(ctl_oe === 1'b0, "R7 turnaround oe off", ctl_oe, 0);
  endtask

  task automatic no_claim(input logic [3:0] cmd, input logic sel, input logic [1:0] typ,
                          input bit abort, input string req);
    @(negedge clk);
    framen = 1'b0; idsel = sel; cben = cmd; ad = {21'h1, 3'd2, 6'd5, typ};
    @(negedge clk);
    idsel = 1'b0; framen = 1'b1; ad = 32'hDEAD_0000; cben = 4'h0;
    irdyn = abort ? 1'b1 : 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(devseln === 1'b1 && ctl_oe === 1'b0, req, {devseln, ctl_oe}, 2'b10);
    end
    bus_idle();
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bus_idle();
    repeat (3) @(negedge clk);
    check(devseln && trdyn && stopn && !ctl_oe && !wr_valid, "R1 reset state",
          {devseln, trdyn, stopn, ctl_oe, wr_valid}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);

    cfg_write(6'd1, 3'd0, 32'h1234_5678, 4'b0000, 0, 1'b0, 21'h0);
    cfg_write(6'd63, 3'd7, 32'hA5A5_0F0F, 4'b1010, 0, 1'b0, 21'h1FFFFF); // R5 upper ignored
    cfg_write(6'd17, 3'd3, 32'h0000_00FF, 4'b1110, 3, 1'b0, 21'h0ABCD);  // R4 master waits

    no_claim(4'b1011, 1'b1, 2'b01, 1'b0, "R2 type-1 address ignored");
    no_claim(4'b1010, 1'b1, 2'b00, 1'b0, "R2 other command ignored");
    no_claim(4'b1011, 1'b0, 2'b00, 1'b0, "R2 idsel low ignored");
    no_claim(4'b1011, 1'b1, 2'b00, 1'b1, "R8 decode abort");

    // R10: first item stalls in the slot, second transaction waits
    wr_ready = 1'b0;
    cfg_write(6'd2, 3'd1, 32'hCAFE_BABE, 4'b0011, 0, 1'b0, 21'h0);
    @(negedge clk);
    check(wr_valid === 1'b1 && wr_data === 32'hCAFE_BABE, "R9 item held",
          wr_data, 32'hCAFE_BABE);
    cfg_write(6'd40, 3'd6, 32'h0BAD_F00D, 4'b0101, 0, 1'b1, 21'h0);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 all items consumed", exp_q.size(), 0);
    check(!wr_valid && ctl_oe === 1'b0, "R7 idle at end", {wr_valid, ctl_oe}, 2'b00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule